// File: doc/BRIEF.md
# Nibble-Bus Memory Read Target

This block is the device end of a clocked, 4-bit multiplexed firmware-hub style bus. On every rising clock edge it samples the shared nibble lines. When it is idle and sees the read start code, it follows a fixed seventeen-clock read cycle:

- It compares the next nibble with its ID straps. A mismatch drops the cycle.
- It shifts in a 28-bit address, most significant nibble first.
- It accepts only the single-byte size code.
- It takes the bus through a two-clock turnaround, drives a ready sync nibble, returns one byte low nibble first, parks the lines high and hands the bus back.

The byte comes from the storage array through a simple request/response port. A one-cycle request pulse carries the full address in the clock after the last address nibble. The array answers with a valid strobe and the byte. That response must arrive before the ready sync clock ends. Nothing else in the device needs to know the bus protocol.

Top module: `nbus_rd_target`

## Requirements
- R1: In idle, a sampled nibble of 1101b starts a read cycle (clock 1). Any other nibble in idle leaves `bus_oe` low and starts nothing.
- R2: The nibble of clock 2 is compared with `id_strap`. On a mismatch, `bus_oe` stays low for the whole cycle, no memory request is made, and the block is ready for a new start nibble from clock 3 onward.
- R3: Clocks 3 to 9 carry address bits 27:24 first and bits 3:0 last. During clock 10, `mem_req` is high for exactly one cycle and `mem_addr` holds the assembled address.
- R4: A size nibble in clock 10 other than 0000b aborts the cycle. `bus_oe` never rises for that cycle.
- R5: In clock 12 the block enables its output and drives 1111b. In clock 13 it drives the ready sync nibble 0000b.
- R6: In clock 14 the block drives bits 3:0 of the byte last delivered with `mem_rvalid`. In clock 15 it drives bits 7:4.
- R7: In clock 16 the block drives 1111b. In clock 17 `bus_oe` is low. A start nibble in clock 18 begins the next cycle with no gap.
- R8: A low `rst_n` sampled at a clock edge forces `bus_oe` and `mem_req` low, clears `mem_addr` to zero and returns to idle, even in the middle of a cycle.
- R9: Each cycle that passes the ID check produces exactly one `mem_req` pulse. The output stays enabled for exactly five consecutive clocks (12 to 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble driven onto the bus when enabled |
| bus_oe | output | 1 | Output enable for `bus_out` |
| id_strap | input | 4 | Device ID straps matched against clock 2 |
| mem_req | output | 1 | One-cycle byte read request to the array |
| mem_addr | output | 28 | Address of the requested byte |
| mem_rvalid | input | 1 | Array marks `mem_rdata` valid |
| mem_rdata | input | 8 | Byte returned by the array |

## Verification
The byte request goes out in clock 10, the same clock in which the size nibble is judged. A cycle with a non-zero size therefore has a request already issued when the abort decision is made. The bench provokes this with a size-0001b cycle. It expects the `mem_req` pulse with the correct address in clock 10, and it expects `bus_oe` to stay low through clock 17. The end of one cycle and the start of the next also meet: back-to-back cycles put a start nibble in the clock right after the release clock, and the scoreboard expects the second cycle to run in full.

// File: rtl/nbus_pkg.sv
// Package: shared constants and sequencer state type for the nibble-bus
// read target. Assumes a 4-bit bus and single-byte transfers.
package nbus_pkg;
    localparam int NIB_W = 4;
    localparam logic [NIB_W-1:0] START_CODE = 4'hD;
    localparam logic [NIB_W-1:0] PARK_CODE  = 4'hF;
    localparam logic [NIB_W-1:0] READY_CODE = 4'h0;
    localparam logic [NIB_W-1:0] SIZE_BYTE  = 4'h0;

    // One state per bus clock of the read cycle (address clocks share one).
    typedef enum logic [3:0] {
        ST_IDLE, ST_IDSEL, ST_ADDR, ST_SIZE, ST_TAR0, ST_TAR1,
        ST_RSYNC, ST_DLO, ST_DHI, ST_REL0, ST_REL1
    } seq_state_t;
endpackage

// File: rtl/nbus_seq.sv
// Module: cycle sequencer. Tracks which clock of a read cycle the bus is in,
// judges start code, ID and size nibbles, and flags address nibble clocks.
// Assumes the host never inserts wait states.
module nbus_seq
    import nbus_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] bus_in,
    input  logic [NIB_W-1:0] id_strap,
    output seq_state_t       state,
    output logic             shift_en,
    output logic             last_nib
);
    localparam int CNT_W = (ADDR_NIBBLES > 1) ? $clog2(ADDR_NIBBLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_NIBBLES - 1);

    logic [CNT_W-1:0] nib_cnt;

    // Address nibble flags, decoded from the current state and count.
    assign shift_en = (state == ST_ADDR);
    assign last_nib = shift_en && (nib_cnt == LAST_CNT);

    // State and address-count update, one step per bus clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nib_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (bus_in == START_CODE) state <= ST_IDSEL;
                ST_IDSEL: begin
                    nib_cnt <= '0;
                    state   <= (bus_in == id_strap) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    if (last_nib) state <= ST_SIZE;
                    else          nib_cnt <= nib_cnt + 1'b1;
                end
                ST_SIZE:  state <= (bus_in == SIZE_BYTE) ? ST_TAR0 : ST_IDLE;
                ST_TAR0:  state <= ST_TAR1;
                ST_TAR1:  state <= ST_RSYNC;
                ST_RSYNC: state <= ST_DLO;
                ST_DLO:   state <= ST_DHI;
                ST_DHI:   state <= ST_REL0;
                ST_REL0:  state <= ST_REL1;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nbus_addr_col.sv
// Module: address collector. Shifts address nibbles in MSB first and raises a
// one-cycle read request after the final nibble. Assumes shift_en marks only
// address clocks of an ID-matched cycle.
module nbus_addr_col
    import nbus_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              last_nib,
    input  logic [NIB_W-1:0]  nib_in,
    output logic [ADDR_W-1:0] addr,
    output logic              req
);
    // Shift register for the address and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            req  <= 1'b0;
        end else begin
            if (shift_en) addr <= {addr[ADDR_W-NIB_W-1:0], nib_in};
            req <= last_nib;
        end
    end
endmodule

// File: rtl/nbus_drive.sv
// Module: bus driver. Holds the byte from the array and selects the nibble
// and enable for each device-driven clock. Assumes the byte arrives before
// the ready sync clock ends.
module nbus_drive
    import nbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [NIB_W-1:0]  bus_out,
    output logic              bus_oe
);
    logic [DATA_W-1:0] data_q;

    // Capture the returned byte whenever the array marks it valid.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (rd_valid) data_q <= rd_data;
    end

    // Choose the driven nibble and enable from the current clock's state.
    always_comb begin
        bus_oe  = 1'b1;
        bus_out = PARK_CODE;
        case (state)
            ST_TAR1:  bus_out = PARK_CODE;
            ST_RSYNC: bus_out = READY_CODE;
            ST_DLO:   bus_out = data_q[NIB_W-1:0];
            ST_DHI:   bus_out = data_q[2*NIB_W-1:NIB_W];
            ST_REL0:  bus_out = PARK_CODE;
            default:  bus_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/nbus_rd_target.sv
// Module: top of the nibble-bus memory read target. Joins the sequencer,
// address collector and bus driver. Assumes an external tri-state buffer
// controlled by bus_oe and a single-byte array read port.
module nbus_rd_target
    import nbus_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int DATA_W       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  bus_in,
    output logic [3:0]                  bus_out,
    output logic                        bus_oe,
    input  logic [3:0]                  id_strap,
    output logic                        mem_req,
    output logic [ADDR_NIBBLES*4-1:0]   mem_addr,
    input  logic                        mem_rvalid,
    input  logic [DATA_W-1:0]           mem_rdata
);
    localparam int ADDR_W = ADDR_NIBBLES * NIB_W;

    seq_state_t state;
    logic       shift_en;
    logic       last_nib;

    nbus_seq #(.ADDR_NIBBLES(ADDR_NIBBLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .id_strap(id_strap),
        .state(state), .shift_en(shift_en), .last_nib(last_nib)
    );

    nbus_addr_col #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .last_nib(last_nib),
        .nib_in(bus_in), .addr(mem_addr), .req(mem_req)
    );

    nbus_drive #(.DATA_W(DATA_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .state(state), .rd_valid(mem_rvalid),
        .rd_data(mem_rdata), .bus_out(bus_out), .bus_oe(bus_oe)
    );
endmodule

// File: rtl/nbus_rd_target_chk.sv
// Module: protocol checker bound to the read target. Watches only top-level
// ports; a run counter measures how long the output stays enabled.
module nbus_rd_target_chk #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        bus_out,
    input logic              bus_oe,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr
);
    logic [2:0] oe_run;

    // Count consecutive enabled clocks, saturating at seven.
    always_ff @(posedge clk) begin
        if (!rst_n)                  oe_run <= '0;
        else if (!bus_oe)            oe_run <= '0;
        else if (oe_run != 3'd7)     oe_run <= oe_run + 3'd1;
    end

    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!bus_oe && !mem_req && mem_addr == '0));

    a_r5_takeover_parked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> bus_out == 4'hF);

    a_r5_ready_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |=> (bus_oe && bus_out == 4'h0));

    a_r7_release_parked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> $past(bus_out) == 4'hF);

    a_r9_five_drive_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> oe_run == 3'd5);

    a_r9_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

bind nbus_rd_target nbus_rd_target_chk #(.ADDR_W(ADDR_NIBBLES*4)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_out(bus_out), .bus_oe(bus_oe),
    .mem_req(mem_req), .mem_addr(mem_addr)
);

// File: tb/nbus_rd_target_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected item per bus clock, the
// monitor pops it mid-clock and compares it with the outputs.
module nbus_rd_target_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_in = 4'hD;
    logic [3:0]  id_strap = 4'hA;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        mem_req;
    logic [27:0] mem_addr;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic        oe;
        logic [3:0]  nib;
        logic        req;
        logic [27:0] addr;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    nbus_rd_target u_dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .id_strap(id_strap), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [27:0] a);
        return a[7:0] ^ a[15:8] ^ a[27:20] ^ 8'h5A;
    endfunction

    // Array model: answers one clock after each request.
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem_byte(mem_addr);
    end

    task automatic check(input bit ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Monitor: compare each bus clock against its expected item.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic ok;
                e  = sb_q.pop_front();
                ok = (bus_oe == e.oe) && (mem_req == e.req) &&
                     (!e.oe || bus_out == e.nib) &&
                     (!e.req || mem_addr == e.addr);
                check(ok, e.tag, $sformatf(
                    "oe=%0b out=%h req=%0b addr=%h expected oe=%0b out=%h req=%0b addr=%h",
                    bus_oe, bus_out, mem_req, mem_addr, e.oe, e.nib, e.req, e.addr));
            end
        end
    end

    // Driver: present one nibble for one bus clock and push its expectation.
    task automatic step(input logic [3:0] v, input logic oe, input logic [3:0] nib,
                        input logic req, input logic [27:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        bus_in = v;
        e.oe = oe; e.nib = nib; e.req = req; e.addr = a; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Full read cycle of seventeen clocks; last_clk limits how far it goes.
    task automatic read_cycle(input logic [3:0] id, input logic [27:0] a,
                              input logic [3:0] size, input int last_clk);
        logic match, act;
        logic [7:0] d;
        match = (id == id_strap);
        act   = match && (size == 4'h0);
        d     = mem_byte(a);
        step(4'hD, 0, 4'h0, 0, '0, "R1");
        if (last_clk < 2) return;
        step(id, 0, 4'h0, 0, '0, "R2");
        for (int i = 0; i < 7; i++) step(a[27-4*i -: 4], 0, 4'h0, 0, '0, "R3");
        step(size, 0, 4'h0, match, a, match ? "R3" : "R2");
        step(4'hF, 0, 4'h0, 0, '0, act ? "R5" : "R4");
        step(4'hF, act, 4'hF, 0, '0, act ? "R5" : "R4");
        step(4'hF, act, 4'h0, 0, '0, act ? "R5" : "R4");
        if (last_clk < 14) return;
        step(4'hF, act, d[3:0], 0, '0, act ? "R6" : "R4");
        step(4'hF, act, d[7:4], 0, '0, act ? "R6" : "R4");
        step(4'hF, act, 4'hF, 0, '0, act ? "R7" : "R4");
        step(4'hF, 0, 4'h0, 0, '0, "R7");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R8: reset held with a start nibble on the bus.
        repeat (3) begin
            @(negedge clk);
            #1;
            check(!bus_oe && !mem_req && mem_addr == '0, "R8",
                  $sformatf("oe=%0b req=%0b addr=%h expected 0 0 0", bus_oe, mem_req, mem_addr));
        end
        @(negedge clk);
        rst_n = 1'b1;
        bus_in = 4'hC;
        // R1: idle noise must not start a cycle.
        step(4'hC, 0, 0, 0, '0, "R1");
        step(4'h5, 0, 0, 0, '0, "R1");
        step(4'h0, 0, 0, 0, '0, "R1");
        step(4'hF, 0, 0, 0, '0, "R1");
        // R3/R5/R6/R7: matched cycle.
        read_cycle(4'hA, 28'h1234567, 4'h0, 17);
        step(4'hF, 0, 0, 0, '0, "R7");
        // R2: wrong ID, then a good cycle must still work.
        read_cycle(4'h5, 28'h0A0B0C0, 4'h0, 17);
        read_cycle(4'hA, 28'h89ABCEF, 4'h0, 17);
        // R4: non-zero size aborts though the request already went out.
        read_cycle(4'hA, 28'h2468ACE, 4'h1, 17);
        step(4'hF, 0, 0, 0, '0, "R4");
        // R7/R9: back-to-back cycles with other straps.
        @(negedge clk);
        id_strap = 4'h0;
        sb_q.push_back('{oe: 1'b0, nib: 4'h0, req: 1'b0, addr: '0, tag: "R7"});
        read_cycle(4'h0, 28'hFFFFFFF, 4'h0, 17);
        read_cycle(4'h0, 28'h0000000, 4'h0, 17);
        read_cycle(4'h0, 28'h7E5C3A1, 4'h0, 17);
        // R8: reset in the middle of a cycle while the output is enabled.
        read_cycle(4'h0, 28'h1357BDF, 4'h0, 13);
        @(negedge clk);
        rst_n  = 1'b0;
        bus_in = 4'hF;
        repeat (2) begin
            @(negedge clk);
            #1;
            check(!bus_oe && !mem_req && mem_addr == '0, "R8",
                  $sformatf("mid-cycle oe=%0b req=%0b addr=%h expected 0 0 0",
                            bus_oe, mem_req, mem_addr));
        end
        rst_n = 1'b1;
        step(4'hF, 0, 0, 0, '0, "R8");
        read_cycle(4'h0, 28'h0C0FFEE, 4'h0, 17);
        step(4'hF, 0, 0, 0, '0, "R1");
        @(negedge clk);
        #2;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule